// File: doc/BRIEF.md
# Capture Timing Micro-Sequencer

This block is a small programmable controller that runs the capture timing of an imaging sensor. Its program is written into an on-chip instruction memory at boot, and a second memory holds user-defined wave definitions. After a start pulse it fetches and executes one instruction per clock. Sequential instructions do register arithmetic and flow control, drive a configuration write strobe toward on-chip analog and digital state, switch the clock frequency-lock loop on or off, and load the clock generator counters.

A wave instruction names a start address in the wave memory. The playback engine then walks a list of entries. Each entry names one control line, the level to give it, and a delay relative to the previous event. Several pixel and analog control lines can be set this way, each with its own rise and fall times, over waves of any length. Instruction fetch waits while a wave plays. Control lines keep their levels until another entry changes them.

Top module: `capture_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, every control line is low, lockEnable is low, busy is low, and cfgValid and cntLoad are low.
- R2: A start pulse while idle begins execution at program address 0 and executes one instruction per clock. Instruction word, from the top bit down: opcode (4 bits), destination register field, source register field, and a DATA_W-bit immediate in the low bits. SETSTATE (opcode 9) raises cfgValid for one cycle, with cfgAddr equal to the low CFG_AW bits of the immediate and cfgData equal to the source register.
- R3: LOADI (opcode 1) writes the immediate to the destination register. ADD (opcode 2) writes destination plus source. SUBI (opcode 3) writes destination minus immediate. All results are modulo 2^DATA_W, and each of these three sets the zero flag when its result is zero and clears it otherwise.
- R4: JUMP (opcode 4) always branches. BZ (opcode 5) branches when the zero flag is set, and BNZ (opcode 6) branches when it is clear. The target is the low address bits of the immediate. An untaken branch falls through, and instructions that are jumped over have no effect at any output.
- R5: SETLOOP (opcode 8) loads the loop counter from the immediate. LOOP (opcode 7) decrements the counter and branches to its target when the counter is above 1. Otherwise it clears the counter and falls through, so a body closed by LOOP runs N times for N of at least 1.
- R6: LOCK (opcode 10) sets lockEnable to bit 0 of the immediate and holds it there. CLKLOAD (opcode 11) raises cntLoad for one cycle, with cntValue equal to the source register.
- R7: WAVE (opcode 12) plays the wave memory from the address in its immediate. Wave entry, from the top bit down: end marker, level, signal index, and a DLY_W-bit delay in the low bits. Each entry sets its line delay+1 cycles after the previous event, where the first entry counts from the WAVE instruction.
- R8: No instruction executes during playback. Reaching the end marker takes one cycle, and the instruction after the WAVE executes in the following cycle. A wave whose first entry is the end marker therefore occupies one cycle.
- R9: Control lines hold their last levels between waves and after a halt. An entry changes only the line it indexes, and an entry that writes a line's present level changes nothing.
- R10: HALT (opcode 15) returns the block to idle, with busy falling in the cycle it executes. A later start begins again at address 0, and the control lines keep their levels. Opcodes 0, 13 and 14 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin execution at address 0 when idle |
| progWe | input | 1 | Instruction memory write enable |
| progAddr | input | PC_AW | Instruction memory write address |
| progData | input | INSTR_W | Instruction memory write data |
| waveWe | input | 1 | Wave memory write enable |
| waveAddr | input | WA_W | Wave memory write address |
| waveData | input | WAVE_W | Wave memory write data |
| ctrlOut | output | NUM_SIG | Pixel and analog control lines |
| cfgValid | output | 1 | One-cycle configuration write strobe |
| cfgAddr | output | CFG_AW | Configuration target address |
| cfgData | output | DATA_W | Configuration write value |
| lockEnable | output | 1 | Frequency-lock loop enable |
| cntLoad | output | 1 | One-cycle clock counter load strobe |
| cntValue | output | DATA_W | Clock counter load value |
| busy | output | 1 | High while a program runs |

## Verification
The bench builds the block with four control lines, a 4-bit delay field, a 32-word program memory and a 16-entry wave memory. The narrow delay field makes the largest delay of 15, and so the widest 16-cycle gap between edges, cheap to reach. Four lines keep every index visible in one short wave. With these values the bench can time a two-pass loop around a wave, an empty wave, and a re-write of a line to its present level, all cycle by cycle.

// File: rtl/capseq_pkg.sv
package capseq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_LDI   = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUBI  = 4'd3,
    OP_JMP   = 4'd4,
    OP_BZ    = 4'd5,
    OP_BNZ   = 4'd6,
    OP_LOOP  = 4'd7,
    OP_SETLC = 4'd8,
    OP_SETST = 4'd9,
    OP_LOCK  = 4'd10,
    OP_CLKLD = 4'd11,
    OP_WAVE  = 4'd12,
    OP_HALT  = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_IMM,
    ALU_ADD,
    ALU_SUBI
  } aluOp_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic   regWr;
    logic   flagWr;
    aluOp_e aluOp;
    logic   cfgWr;
    logic   lockWr;
    logic   cntWr;
    logic   lcLoad;
    logic   lcStep;
    logic   sigWr;
  } dpStrobe_t;

endpackage

// File: rtl/capseq_mem.sv
module capseq_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [W-1:0]  wData,
  input  logic [AW-1:0] rAddr,
  output logic [W-1:0]  rData
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
  end

  // read is combinational so an instruction executes in the cycle it is addressed
  assign rData = mem[rAddr];

endmodule

// File: rtl/capseq_ctrl.sv
module capseq_ctrl
  import capseq_pkg::*;
#(
  parameter int PC_AW = 6,
  parameter int WA_W  = 6,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OP_W-1:0]  opBits,
  input  logic [PC_AW-1:0] target,
  input  logic [WA_W-1:0]  waveBase,
  output logic [PC_AW-1:0] pc,
  input  logic             entryEnd,
  input  logic [DLY_W-1:0] entryDly,
  output logic [WA_W-1:0]  wavePtr,
  input  logic             zeroFlag,
  input  logic             lcLast,
  output dpStrobe_t        stb,
  output logic             busy,
  output logic             waveActive
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAVE} state_e;

  state_e           state;
  opcode_e          op;
  logic [DLY_W-1:0] waitCnt;
  logic             eventDue;
  logic             takeBranch;

  assign op         = opcode_e'(opBits);
  assign busy       = (state != S_IDLE);
  assign waveActive = (state == S_WAVE);
  assign eventDue   = waveActive && !entryEnd && (waitCnt == entryDly);

  always_comb begin
    case (op)
      OP_JMP:  takeBranch = 1'b1;
      OP_BZ:   takeBranch = zeroFlag;
      OP_BNZ:  takeBranch = !zeroFlag;
      OP_LOOP: takeBranch = !lcLast;
      default: takeBranch = 1'b0;
    endcase
  end

  always_comb begin
    stb       = '0;
    stb.aluOp = ALU_IMM;
    if (state == S_RUN) begin
      case (op)
        OP_LDI:   begin stb.regWr = 1'b1; stb.flagWr = 1'b1; stb.aluOp = ALU_IMM;  end
        OP_ADD:   begin stb.regWr = 1'b1; stb.flagWr = 1'b1; stb.aluOp = ALU_ADD;  end
        OP_SUBI:  begin stb.regWr = 1'b1; stb.flagWr = 1'b1; stb.aluOp = ALU_SUBI; end
        OP_SETST: stb.cfgWr  = 1'b1;
        OP_LOCK:  stb.lockWr = 1'b1;
        OP_CLKLD: stb.cntWr  = 1'b1;
        OP_SETLC: stb.lcLoad = 1'b1;
        OP_LOOP:  stb.lcStep = 1'b1;
        default:  ;
      endcase
    end
    stb.sigWr = eventDue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pc      <= '0;
      wavePtr <= '0;
      waitCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            pc    <= '0;
            state <= S_RUN;
          end
        end
        S_RUN: begin
          pc <= takeBranch ? target : pc + 1'b1;
          if (op == OP_WAVE) begin
            wavePtr <= waveBase;
            waitCnt <= '0;
            state   <= S_WAVE;
          end else if (op == OP_HALT) begin
            state <= S_IDLE;
          end
        end
        S_WAVE: begin
          if (entryEnd) begin
            state <= S_RUN;
          end else if (eventDue) begin
            wavePtr <= wavePtr + 1'b1;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/capseq_dp.sv
module capseq_dp
  import capseq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NREG    = 4,
  parameter int NUM_SIG = 8,
  parameter int CFG_AW  = 8,
  parameter int REG_AW  = 2,
  parameter int SIG_AW  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [REG_AW-1:0] rd,
  input  logic [REG_AW-1:0] rs,
  input  logic [DATA_W-1:0] imm,
  input  logic [SIG_AW-1:0] sigSel,
  input  logic              sigLevel,
  output logic              zeroFlag,
  output logic              lcLast,
  output logic [NUM_SIG-1:0] ctrlOut,
  output logic              cfgValid,
  output logic [CFG_AW-1:0] cfgAddr,
  output logic [DATA_W-1:0] cfgData,
  output logic              lockEnable,
  output logic              cntLoad,
  output logic [DATA_W-1:0] cntValue
);

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] aluRes;
  logic [DATA_W-1:0] loopCnt;

  always_comb begin
    case (stb.aluOp)
      ALU_ADD:  aluRes = regs[rd] + regs[rs];
      ALU_SUBI: aluRes = regs[rd] - imm;
      default:  aluRes = imm;
    endcase
  end

  assign lcLast = (loopCnt[DATA_W-1:1] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      zeroFlag <= 1'b0;
    end else begin
      if (stb.regWr)  regs[rd] <= aluRes;
      if (stb.flagWr) zeroFlag <= (aluRes == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopCnt <= '0;
    end else if (stb.lcLoad) begin
      loopCnt <= imm;
    end else if (stb.lcStep) begin
      loopCnt <= lcLast ? '0 : loopCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlOut <= '0;
    end else if (stb.sigWr) begin
      ctrlOut[sigSel] <= sigLevel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgValid   <= 1'b0;
      cfgAddr    <= '0;
      cfgData    <= '0;
      lockEnable <= 1'b0;
      cntLoad    <= 1'b0;
      cntValue   <= '0;
    end else begin
      cfgValid <= stb.cfgWr;
      cntLoad  <= stb.cntWr;
      if (stb.cfgWr) begin
        cfgAddr <= imm[CFG_AW-1:0];
        cfgData <= regs[rs];
      end
      if (stb.cntWr)  cntValue   <= regs[rs];
      if (stb.lockWr) lockEnable <= imm[0];
    end
  end

endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
  import capseq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NREG       = 4,
  parameter int PROG_DEPTH = 64,
  parameter int WAVE_DEPTH = 64,
  parameter int NUM_SIG    = 8,
  parameter int DLY_W      = 8,
  parameter int CFG_AW     = 8,
  localparam int REG_AW    = $clog2(NREG),
  localparam int PC_AW     = $clog2(PROG_DEPTH),
  localparam int WA_W      = $clog2(WAVE_DEPTH),
  localparam int SIG_AW    = $clog2(NUM_SIG),
  localparam int INSTR_W   = OP_W + 2 * REG_AW + DATA_W,
  localparam int WAVE_W    = 2 + SIG_AW + DLY_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               progWe,
  input  logic [PC_AW-1:0]   progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic               waveWe,
  input  logic [WA_W-1:0]    waveAddr,
  input  logic [WAVE_W-1:0]  waveData,
  output logic [NUM_SIG-1:0] ctrlOut,
  output logic               cfgValid,
  output logic [CFG_AW-1:0]  cfgAddr,
  output logic [DATA_W-1:0]  cfgData,
  output logic               lockEnable,
  output logic               cntLoad,
  output logic [DATA_W-1:0]  cntValue,
  output logic               busy
);

  logic [PC_AW-1:0]   pc;
  logic [INSTR_W-1:0] instr;
  logic [WA_W-1:0]    wavePtr;
  logic [WAVE_W-1:0]  entry;
  logic               zeroFlag;
  logic               lcLast;
  logic               waveActive;
  dpStrobe_t          stb;

  logic [DATA_W-1:0]  imm;
  logic [REG_AW-1:0]  rdSel;
  logic [REG_AW-1:0]  rsSel;

  assign imm   = instr[DATA_W-1:0];
  assign rsSel = instr[DATA_W+REG_AW-1 -: REG_AW];
  assign rdSel = instr[DATA_W+2*REG_AW-1 -: REG_AW];

  capseq_mem #(.W(INSTR_W), .DEPTH(PROG_DEPTH)) uProg (
    .clk  (clk),
    .we   (progWe),
    .wAddr(progAddr),
    .wData(progData),
    .rAddr(pc),
    .rData(instr)
  );

  capseq_mem #(.W(WAVE_W), .DEPTH(WAVE_DEPTH)) uWave (
    .clk  (clk),
    .we   (waveWe),
    .wAddr(waveAddr),
    .wData(waveData),
    .rAddr(wavePtr),
    .rData(entry)
  );

  capseq_ctrl #(.PC_AW(PC_AW), .WA_W(WA_W), .DLY_W(DLY_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .opBits    (instr[INSTR_W-1 -: OP_W]),
    .target    (imm[PC_AW-1:0]),
    .waveBase  (imm[WA_W-1:0]),
    .pc        (pc),
    .entryEnd  (entry[WAVE_W-1]),
    .entryDly  (entry[DLY_W-1:0]),
    .wavePtr   (wavePtr),
    .zeroFlag  (zeroFlag),
    .lcLast    (lcLast),
    .stb       (stb),
    .busy      (busy),
    .waveActive(waveActive)
  );

  capseq_dp #(
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .NUM_SIG(NUM_SIG),
    .CFG_AW (CFG_AW),
    .REG_AW (REG_AW),
    .SIG_AW (SIG_AW)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rd        (rdSel),
    .rs        (rsSel),
    .imm       (imm),
    .sigSel    (entry[DLY_W+SIG_AW-1 -: SIG_AW]),
    .sigLevel  (entry[WAVE_W-2]),
    .zeroFlag  (zeroFlag),
    .lcLast    (lcLast),
    .ctrlOut   (ctrlOut),
    .cfgValid  (cfgValid),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .lockEnable(lockEnable),
    .cntLoad   (cntLoad),
    .cntValue  (cntValue)
  );

endmodule

// File: rtl/capture_sequencer_chk.sv
module capture_sequencer_chk #(
  parameter int NUM_SIG = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SIG-1:0] ctrlOut,
  input logic               cfgValid,
  input logic               cntLoad,
  input logic               lockEnable,
  input logic               busy,
  input logic               waveActive
);

  // R1: first edge after reset release still shows the reset state
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ctrlOut == '0 && !lockEnable && !busy && !cfgValid && !cntLoad));

  // R2: a configuration strobe only follows an instruction executed outside playback
  a_r2_cfg_from_run: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> ($past(busy) && !$past(waveActive)));

  // R6: a counter load strobe only follows an instruction executed outside playback
  a_r6_cnt_from_run: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |-> ($past(busy) && !$past(waveActive)));

  // R7: playback moves at most one line per cycle
  a_r7_one_line_per_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ctrlOut ^ $past(ctrlOut)) <= 1);

  // R9: lines change only as a result of playback
  a_r9_lines_only_in_wave: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlOut) |-> $past(waveActive));

  // R10: an idle block holds every output
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> ($stable(ctrlOut) && $stable(lockEnable) && !cfgValid && !cntLoad));

endmodule

bind capture_sequencer capture_sequencer_chk #(.NUM_SIG(NUM_SIG)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlOut   (ctrlOut),
  .cfgValid  (cfgValid),
  .cntLoad   (cntLoad),
  .lockEnable(lockEnable),
  .busy      (busy),
  .waveActive(waveActive)
);

// File: tb/capture_sequencer_test.sv
module capture_sequencer_test;

  localparam int DW = 16;
  localparam int NR = 4;
  localparam int PD = 32;
  localparam int WD = 16;
  localparam int NS = 4;
  localparam int DL = 4;
  localparam int CA = 8;
  localparam int RA = 2;
  localparam int PA = 5;
  localparam int WA = 4;
  localparam int SA = 2;
  localparam int IW = 4 + 2 * RA + DW;
  localparam int WW = 2 + SA + DL;

  // opcode values from the requirements
  localparam logic [3:0] C_LDI = 4'd1, C_ADD = 4'd2, C_SUBI = 4'd3, C_JMP = 4'd4,
                         C_BZ = 4'd5, C_BNZ = 4'd6, C_LOOP = 4'd7, C_SETLC = 4'd8,
                         C_SETST = 4'd9, C_LOCK = 4'd10, C_CLKLD = 4'd11,
                         C_WAVE = 4'd12, C_HALT = 4'd15;

  localparam int K_CTRL = 0, K_CFG = 1, K_CNT = 2, K_LOCK = 3, K_DONE = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          progWe = 1'b0;
  logic [PA-1:0] progAddr = '0;
  logic [IW-1:0] progData = '0;
  logic          waveWe = 1'b0;
  logic [WA-1:0] waveAddr = '0;
  logic [WW-1:0] waveData = '0;
  logic [NS-1:0] ctrlOut;
  logic          cfgValid;
  logic [CA-1:0] cfgAddr;
  logic [DW-1:0] cfgData;
  logic          lockEnable;
  logic          cntLoad;
  logic [DW-1:0] cntValue;
  logic          busy;

  capture_sequencer #(
    .DATA_W(DW), .NREG(NR), .PROG_DEPTH(PD), .WAVE_DEPTH(WD),
    .NUM_SIG(NS), .DLY_W(DL), .CFG_AW(CA)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .waveWe(waveWe), .waveAddr(waveAddr), .waveData(waveData),
    .ctrlOut(ctrlOut), .cfgValid(cfgValid), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .lockEnable(lockEnable), .cntLoad(cntLoad), .cntValue(cntValue), .busy(busy)
  );

  typedef struct {
    int     kind;
    longint val;
    int     at;
    string  req;
  } item_t;

  item_t         expq[$];
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  bit            finished = 0;
  logic [WW-1:0] wmodel [WD];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [IW-1:0] ins(logic [3:0] op, int rd, int rs, logic [DW-1:0] imm);
    logic [RA-1:0] d = rd[RA-1:0];
    logic [RA-1:0] s = rs[RA-1:0];
    return {op, d, s, imm};
  endfunction

  function automatic logic [WW-1:0] wv(bit e, bit l, int s, int d);
    logic [SA-1:0] si = s[SA-1:0];
    logic [DL-1:0] di = d[DL-1:0];
    return {e, l, si, di};
  endfunction

  function automatic string reqOf(int kind);
    case (kind)
      K_CTRL:  return "R7";
      K_CFG:   return "R2";
      K_CNT:   return "R6";
      K_LOCK:  return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void expectEv(int kind, longint val, int at, string req);
    item_t it;
    it.kind = kind; it.val = val; it.at = at; it.req = req;
    expq.push_back(it);
  endfunction

  // monitor side of the scoreboard
  task automatic observe(int kind, longint val);
    item_t e;
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event kind %0d: actual value %0h at cycle %0d, expected no event",
               reqOf(kind), kind, val, cyc);
    end else begin
      e = expq.pop_front();
      if (e.kind != kind || e.val != val || e.at != cyc) begin
        errors++;
        $display("FAIL %s event: actual kind %0d value %0h cycle %0d, expected kind %0d value %0h cycle %0d",
                 e.req, kind, val, cyc, e.kind, e.val, e.at);
      end
    end
  endtask

  initial begin
    logic [NS-1:0] prevCtrl = '0;
    logic          prevLock = 1'b0;
    logic          prevBusy = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (ctrlOut !== prevCtrl) observe(K_CTRL, longint'(ctrlOut));
        if (cfgValid)             observe(K_CFG, longint'({cfgAddr, cfgData}));
        if (cntLoad)              observe(K_CNT, longint'(cntValue));
        if (lockEnable !== prevLock) observe(K_LOCK, longint'(lockEnable));
        if (prevBusy && !busy)    observe(K_DONE, 0);
      end
      prevCtrl = ctrlOut;
      prevLock = lockEnable;
      prevBusy = busy;
    end
  end

  task automatic putInstr(int a, logic [IW-1:0] w);
    @(negedge clk);
    progWe = 1'b1; progAddr = a[PA-1:0]; progData = w;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic putWave(int a, logic [WW-1:0] w);
    @(negedge clk);
    waveWe = 1'b1; waveAddr = a[WA-1:0]; waveData = w;
    wmodel[a] = w;
    @(negedge clk);
    waveWe = 1'b0;
  endtask

  // reference timing of a wave from the requirements: entry after delay+1, end marker one cycle
  task automatic modelWave(input int base, inout int t, inout logic [NS-1:0] lvl, input string req);
    int p = base;
    while (!wmodel[p][WW-1]) begin
      int s = int'(wmodel[p][DL+SA-1 -: SA]);
      t += int'(wmodel[p][DL-1:0]) + 1;
      if (lvl[s] != wmodel[p][WW-2]) begin
        lvl[s] = wmodel[p][WW-2];
        expectEv(K_CTRL, longint'(lvl), t, req);
      end
      p++;
    end
    t += 1;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && expq.size() > 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, req, "pending expected events", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual still running, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    logic [NS-1:0] lvl;

    repeat (3) @(negedge clk);
    // R1 during reset
    check(ctrlOut == '0, "R1", "lines in reset", ctrlOut, 0);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(lockEnable == 1'b0, "R1", "lock after reset", lockEnable, 0);
    check(!cfgValid && !cntLoad, "R1", "strobes after reset", {cfgValid, cntLoad}, 0);

    // program A: arithmetic, branches, state writes
    putInstr(0,  ins(C_LDI,   1, 0, 16'd5));
    putInstr(1,  ins(C_LDI,   2, 0, 16'hFFFF));
    putInstr(2,  ins(C_ADD,   1, 2, 16'd0));      // 5 + FFFF wraps to 4
    putInstr(3,  ins(C_SETST, 0, 1, 16'h0012));
    putInstr(4,  ins(C_SUBI,  1, 0, 16'd4));      // zero
    putInstr(5,  ins(C_BZ,    0, 0, 16'd7));
    putInstr(6,  ins(C_SETST, 0, 1, 16'h0099));   // jumped over
    putInstr(7,  ins(C_SETST, 0, 1, 16'h0021));
    putInstr(8,  ins(C_LOCK,  0, 0, 16'd1));
    putInstr(9,  ins(C_LDI,   3, 0, 16'h0ABC));   // clears zero
    putInstr(10, ins(C_CLKLD, 0, 3, 16'd0));
    putInstr(11, ins(C_BNZ,   0, 0, 16'd13));
    putInstr(12, ins(C_SETST, 0, 1, 16'h0077));   // jumped over
    putInstr(13, ins(C_LOCK,  0, 0, 16'd0));
    putInstr(14, ins(C_HALT,  0, 0, 16'd0));

    @(negedge clk);
    t = cyc + 1;
    t += 3;                                        // LDI, LDI, ADD
    t += 1; expectEv(K_CFG, longint'({8'h12, 16'd4}), t, "R3");
    t += 2;                                        // SUBI, BZ taken
    t += 1; expectEv(K_CFG, longint'({8'h21, 16'd0}), t, "R4");
    t += 1; expectEv(K_LOCK, 1, t, "R6");
    t += 1;                                        // LDI
    t += 1; expectEv(K_CNT, longint'(16'h0ABC), t, "R6");
    t += 1;                                        // BNZ taken
    t += 1; expectEv(K_LOCK, 0, t, "R4");
    t += 1; expectEv(K_DONE, 0, t, "R10");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain("R2");
    check(busy == 1'b0, "R10", "busy after halt", busy, 0);
    check(lockEnable == 1'b0, "R6", "lock held low", lockEnable, 0);

    // waves
    putWave(0, wv(0, 1, 0, 2));
    putWave(1, wv(0, 1, 2, 0));
    putWave(2, wv(0, 0, 0, 15));                   // largest delay
    putWave(3, wv(1, 0, 0, 0));
    putWave(4, wv(1, 0, 0, 0));                    // empty wave
    putWave(5, wv(0, 1, 3, 0));
    putWave(6, wv(1, 0, 0, 0));

    // program B: loop around a wave, empty wave, restart at address 0
    putInstr(0, ins(C_SETLC, 0, 0, 16'd2));
    putInstr(1, ins(C_WAVE,  0, 0, 16'd0));
    putInstr(2, ins(C_LOOP,  0, 0, 16'd1));
    putInstr(3, ins(C_WAVE,  0, 0, 16'd4));
    putInstr(4, ins(C_SETST, 0, 0, 16'h0005));
    putInstr(5, ins(C_WAVE,  0, 0, 16'd5));
    putInstr(6, ins(C_HALT,  0, 0, 16'd0));

    @(negedge clk);
    t = cyc + 1;
    lvl = '0;
    t += 1;                                        // SETLC
    for (int it = 0; it < 2; it++) begin
      t += 1;                                      // WAVE
      modelWave(0, t, lvl, (it == 0) ? "R7" : "R5");
      t += 1;                                      // LOOP
    end
    t += 1;
    modelWave(4, t, lvl, "R8");
    t += 1; expectEv(K_CFG, longint'({8'h05, 16'd0}), t, "R8");
    t += 1;
    modelWave(5, t, lvl, "R9");
    t += 1; expectEv(K_DONE, 0, t, "R10");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain("R8");
    repeat (4) @(negedge clk);
    check(ctrlOut == 4'b1100, "R9", "lines held after halt", ctrlOut, 4'b1100);
    check(busy == 1'b0, "R10", "idle after second halt", busy, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule